// File: doc/BRIEF.md
# Two-bit word buffer with destination routing

The block holds one small word in a buffer that stands between addressed memory and a set of working registers. A single started operation does one of four things. It copies the buffer out to one register chosen by a destination code. It refills the buffer from the first data register. It loads the buffer from the memory read data. Or it does nothing. Every operation finishes with a one-cycle done pulse.

Transfers are deliberately lopsided. Any of the four registers can receive the buffer, but the first data register is the only register that can fill the buffer. Inside the block, every bit of every transfer is split into a set path and a clear path. The buffer bit (on write-out) or the source bit (on read-in) enables exactly one of the two. A register bit therefore changes only through the path that matches the value being carried.

Top module: `xfer_buffer_router`

## Requirements
- R1: After reset the buffer, all four registers and `done` are zero.
- R2: A `start` sampled while idle is followed by one busy cycle. `done` is then high for exactly one cycle, and the transfer's result is visible at the outputs in that same cycle.
- R3: A `start` sampled while a transfer is busy or signalling done is ignored. Operation, destination and memory data are captured only when a start is accepted.
- R4: With `op_sel` = 00 (write-out), the buffer value is copied to the register at slice `dest_sel` of `regs_q`. Code 00 is data register 1, 01 is data register 2, 10 is the instruction register and 11 is the reserved register.
- R5: During a write-out, every register not selected by the destination code, and the buffer itself, keep their values.
- R6: With `op_sel` = 01 (read-in), the buffer takes the value of data register 1 (slice 0) whatever the destination code, and no register changes.
- R7: With `op_sel` = 10 (memory load), the buffer takes the `mem_rdata` value sampled with the accepted start, and no register changes.
- R8: For every bit, the set path and the clear path are never active together.
- R9: With `op_sel` = 11, no storage changes, but `done` still pulses as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 2 | Operation: 00 write-out, 01 read-in, 10 memory load, 11 none |
| dest_sel | input | 2 | Destination code for write-out |
| mem_rdata | input | 2 | Memory word for a memory load |
| start | input | 1 | Start request, accepted only while idle |
| done | output | 1 | One-cycle completion pulse |
| buf_q | output | 2 | Buffer contents |
| regs_q | output | 8 | Registers; slice d holds destination code d, two bits each |

## Verification
A wrong destination decode or a broken set or clear path shows up as a wrong slice of `regs_q`. It is visible in the same cycle as the done pulse of that transfer. A slice that should have held its value but moved is caught at that same moment. A controller that takes a start while busy shows up as an extra done pulse or a changed register two cycles after the rejected start. A read-in that takes the wrong source shows up in `buf_q` when `done` rises. The bench sweeps every destination code against every buffer value and compares all outputs after each transfer.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_MEM   = 2'b10,
    OP_NOP   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BUSY = 2'b01,
    ST_DONE = 2'b10
  } st_e;
endpackage

// File: rtl/xbr_ctrl.sv
module xbr_ctrl
  import xbr_pkg::*;
#(
  parameter int unsigned WORD_W = 2,
  parameter int unsigned DEST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op_in,
  input  logic [DEST_W-1:0] dest_in,
  input  logic [WORD_W-1:0] mem_in,
  output logic              fire,
  output logic              done,
  output op_e               op_q,
  output logic [DEST_W-1:0] dest_q,
  output logic [WORD_W-1:0] mem_q
);
  st_e  st_q, st_d;
  logic accept;

  assign accept = start && (st_q == ST_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_BUSY;
      ST_BUSY: st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NOP;
      dest_q <= '0;
      mem_q  <= '0;
    end else if (accept) begin
      op_q   <= op_e'(op_in);
      dest_q <= dest_in;
      mem_q  <= mem_in;
    end
  end

  assign fire = (st_q == ST_BUSY);
  assign done = (st_q == ST_DONE);

  p_busy_then_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> done);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_start_to_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> fire);
  p_reject_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire || done) |=> (!fire && $stable(op_q) && $stable(dest_q) && $stable(mem_q)));
endmodule

// File: rtl/xbr_bitpath.sv
module xbr_bitpath
  import xbr_pkg::*;
#(
  parameter int unsigned DEST_W = 2,
  localparam int unsigned NUM_DEST = 1 << DEST_W
) (
  input  logic                fire,
  input  op_e                 op,
  input  logic [DEST_W-1:0]   dest,
  input  logic                buf_bit,
  input  logic                src_bit,
  input  logic                mem_bit,
  output logic [NUM_DEST-1:0] dst_set,
  output logic [NUM_DEST-1:0] dst_clr,
  output logic                buf_set,
  output logic                buf_clr
);
  logic wr_out, rd_in, mem_ld;

  assign wr_out = fire && (op == OP_WRITE);
  assign rd_in  = fire && (op == OP_READ);
  assign mem_ld = fire && (op == OP_MEM);

  for (genvar d = 0; d < NUM_DEST; d++) begin : g_dst
    logic hit;
    assign hit        = wr_out && (dest == DEST_W'(d));
    assign dst_set[d] = hit &&  buf_bit;
    assign dst_clr[d] = hit && !buf_bit;
  end

  assign buf_set = (rd_in && src_bit)  || (mem_ld && mem_bit);
  assign buf_clr = (rd_in && !src_bit) || (mem_ld && !mem_bit);
endmodule

// File: rtl/xbr_regfile.sv
module xbr_regfile #(
  parameter int unsigned WORD_W = 2,
  parameter int unsigned N_REGS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_REGS-1:0][WORD_W-1:0]  set_en,
  input  logic [N_REGS-1:0][WORD_W-1:0]  clr_en,
  output logic [N_REGS-1:0][WORD_W-1:0]  q
);
  logic [N_REGS-1:0][WORD_W-1:0] q_d;
  logic [N_REGS-1:0]             wen;

  always_comb begin
    q_d = q;
    for (int r = 0; r < N_REGS; r++) begin
      wen[r] = (|set_en[r]) || (|clr_en[r]);
      for (int b = 0; b < WORD_W; b++) begin
        if (set_en[r][b])      q_d[r][b] = 1'b1;
        else if (clr_en[r][b]) q_d[r][b] = 1'b0;
      end
    end
  end

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[r] <= '0;
      else if (wen[r]) q[r] <= q_d[r];
    end
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      p_path_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_en[r][b], clr_en[r][b]}));
    end
  end
endmodule

// File: rtl/xfer_buffer_router.sv
module xfer_buffer_router
  import xbr_pkg::*;
#(
  parameter int unsigned WORD_W = 2,
  parameter int unsigned DEST_W = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [1:0]                      op_sel,
  input  logic [DEST_W-1:0]               dest_sel,
  input  logic [WORD_W-1:0]               mem_rdata,
  input  logic                            start,
  output logic                            done,
  output logic [WORD_W-1:0]               buf_q,
  output logic [(WORD_W<<DEST_W)-1:0]     regs_q
);
  localparam int unsigned NUM_DEST = 1 << DEST_W;

  logic                            fire;
  op_e                             op_l;
  logic [DEST_W-1:0]               dest_l;
  logic [WORD_W-1:0]               mem_l;
  logic [WORD_W-1:0][NUM_DEST-1:0] bp_set, bp_clr;
  logic [NUM_DEST-1:0][WORD_W-1:0] dset, dclr, rq;
  logic [0:0][WORD_W-1:0]          bset, bclr, bq;

  xbr_ctrl #(.WORD_W(WORD_W), .DEST_W(DEST_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_sel),
    .dest_in(dest_sel), .mem_in(mem_rdata), .fire(fire), .done(done),
    .op_q(op_l), .dest_q(dest_l), .mem_q(mem_l)
  );

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    xbr_bitpath #(.DEST_W(DEST_W)) u_path (
      .fire(fire), .op(op_l), .dest(dest_l),
      .buf_bit(bq[0][b]), .src_bit(rq[0][b]), .mem_bit(mem_l[b]),
      .dst_set(bp_set[b]), .dst_clr(bp_clr[b]),
      .buf_set(bset[0][b]), .buf_clr(bclr[0][b])
    );
    for (genvar d = 0; d < NUM_DEST; d++) begin : g_x
      assign dset[d][b] = bp_set[b][d];
      assign dclr[d][b] = bp_clr[b][d];
    end
  end

  xbr_regfile #(.WORD_W(WORD_W), .N_REGS(NUM_DEST)) u_regs (
    .clk(clk), .rst_n(rst_n), .set_en(dset), .clr_en(dclr), .q(rq)
  );

  xbr_regfile #(.WORD_W(WORD_W), .N_REGS(1)) u_buf (
    .clk(clk), .rst_n(rst_n), .set_en(bset), .clr_en(bclr), .q(bq)
  );

  assign buf_q = bq[0];
  for (genvar d = 0; d < NUM_DEST; d++) begin : g_out
    assign regs_q[d*WORD_W +: WORD_W] = rq[d];

    p_write_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && op_l == OP_WRITE && dest_l == DEST_W'(d)) |=> (rq[d] == $past(bq[0])));
    p_hold_unsel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !(op_l == OP_WRITE && dest_l == DEST_W'(d))) |=> $stable(rq[d]));
  end

  p_read_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_l == OP_READ) |=> (bq[0] == $past(rq[0])));
  p_mem_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_l == OP_MEM) |=> (bq[0] == $past(mem_l)));
  p_nop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_l == OP_NOP) |=> ($stable(bq[0]) && $stable(rq)));
endmodule

// File: tb/xfer_buffer_router_tb.sv
module xfer_buffer_router_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] op_sel, dest_sel, mem_rdata;
  logic       start;
  logic       done;
  logic [1:0] buf_q;
  logic [7:0] regs_q;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [1:0] m_buf;
  logic [1:0] m_reg [4];

  always #10 clk = ~clk;

  xfer_buffer_router u_dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .dest_sel(dest_sel),
    .mem_rdata(mem_rdata), .start(start), .done(done),
    .buf_q(buf_q), .regs_q(regs_q)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag_buf, input int sel);
    chk(tag_buf, buf_q, m_buf);
    for (int d = 0; d < 4; d++)
      chk((d == sel) ? "R4 selected register" : "R5 other register",
          regs_q[d*2 +: 2], m_reg[d]);
  endtask

  task automatic do_op(input logic [1:0] op, input logic [1:0] dest, input logic [1:0] mem);
    @(negedge clk);
    op_sel = op; dest_sel = dest; mem_rdata = mem; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_sel = ~op; mem_rdata = ~mem;
    chk("R2 no done while busy", {1'b0, done}, 2'd0);
    @(negedge clk);
    chk("R2 done pulse", {1'b0, done}, 2'd1);
    case (op)
      2'b00: m_reg[dest] = m_buf;
      2'b01: m_buf = m_reg[0];
      2'b10: m_buf = mem;
      default: ;
    endcase
    chk_all(op == 2'b01 ? "R6 read-in source" : op == 2'b10 ? "R7 memory load" :
            op == 2'b11 ? "R9 no-op buffer" : "R5 buffer kept", op == 2'b00 ? int'(dest) : -1);
    @(negedge clk);
    chk("R2 done single cycle", {1'b0, done}, 2'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_sel = '0; dest_sel = '0; mem_rdata = '0;
    m_buf = '0;
    for (int d = 0; d < 4; d++) m_reg[d] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset buffer", buf_q, 2'd0);
    chk("R1 reset done", {1'b0, done}, 2'd0);
    for (int d = 0; d < 4; d++) chk("R1 reset register", regs_q[d*2 +: 2], 2'd0);
    rst_n = 1'b1;

    // R4 R5 R7: every destination code with every data value
    for (int v = 0; v < 4; v++) begin
      for (int d = 0; d < 4; d++) begin
        do_op(2'b10, 2'(d), 2'(v ^ d));
        do_op(2'b00, 2'(d), 2'(v));
      end
    end

    // R6: read-in always takes data register 1, whatever the code
    for (int v = 0; v < 4; v++) begin
      do_op(2'b10, 2'd0, 2'(v));
      do_op(2'b00, 2'd0, 2'd0);
      for (int d = 0; d < 4; d++) begin
        do_op(2'b00, 2'(d == 0 ? 1 : d), 2'd0);
        do_op(2'b10, 2'd0, 2'(~v));
        do_op(2'b01, 2'(d), 2'(~v));
      end
    end

    // R9: no-op code
    do_op(2'b10, 2'd0, 2'd2);
    do_op(2'b11, 2'd1, 2'd1);

    // R3: start held through busy and done, with changed controls
    do_op(2'b10, 2'd0, 2'd3);
    @(negedge clk);
    op_sel = 2'b00; dest_sel = 2'd1; start = 1'b1;
    @(negedge clk);
    op_sel = 2'b10; dest_sel = 2'd2; mem_rdata = 2'd0;
    @(negedge clk);
    chk("R3 done of accepted start", {1'b0, done}, 2'd1);
    m_reg[1] = m_buf;
    @(negedge clk);
    start = 1'b0;
    chk("R3 no second done", {1'b0, done}, 2'd0);
    @(negedge clk);
    chk("R3 no second done later", {1'b0, done}, 2'd0);
    chk_all("R3 buffer untouched by rejected start", 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule